// File: doc/BRIEF.md
# Bounded Hardware Stack Pointer Unit

This block keeps the 8-bit pointer into a 256-word stack memory that is divided into four regions of 64 words. The two upper pointer bits pick the region and are never changed by an adjustment. The six lower bits are the offset inside the region. Offset 0 marks an empty stack, and entries live at offsets 1 to 63.

Each stack operation carries a 3-bit signed adjustment, a zero-check flag and a write-address mode. The block presents the current pointer as the read address. It presents either the current or the adjusted pointer as the write address. Before the operation commits, the block decides whether it would leave the region's bounds. When it would, the block raises a hold and a wakeup request for the fault task, leaves the pointer where it was, and latches which kind of error happened so the fault handler can read it.

The pointer can also be loaded from a bus or restored from a copy taken on a dispatch strobe. Both are refused while a stack access is in progress.

Top module: `stkptr_unit`

## Requirements
- R1: After synchronous reset the pointer is 8'h00 (both the read address and the readback show 0), and both error flags are 0.
- R2: On an accepted stack access, the 3-bit adjust code is read as two's complement and added to the low six pointer bits. Codes 0..3 add 0..3 and codes 4..7 add -4..-1. The upper two bits are unchanged and the new pointer is visible on the next cycle.
- R3: On a stack access by task 0, an offset sum above 63 raises `hold`, sets `ovf_flag`, and leaves the pointer unchanged.
- R4: On a stack access by task 0, an offset sum below 0 raises `hold`, sets `und_flag`, and leaves the pointer unchanged.
- R5: On a stack access by task 0 with `zchk` = 1, an original offset of 0 or an adjusted offset of 0 is an underflow: `hold` rises, `und_flag` is set, and the pointer is unchanged.
- R6: Stack accesses by any task other than 0 never raise `hold` or touch the flags. Their offset sum wraps modulo 64.
- R7: `rd_addr` is always the current pointer. `wr_addr` equals `rd_addr` when `wr_adj` = 0. When `wr_adj` = 1, `wr_addr` is the region bits concatenated with the low six bits of the sum.
- R8: `fault_req` is asserted exactly when `hold` is asserted, in the same cycle as the offending access.
- R9: The two flags keep their values until the next stack access by task 0. That access rewrites both flags, clearing each one that does not apply to it.
- R10: With no stack access, `ld_en` = 1 loads `ld_val` into the pointer on the next cycle.
- R11: `save_stb` copies the current pointer into a saved register. With no stack access and no load, `restore_en` = 1 copies the saved value back into the pointer. A load takes priority over a restore.
- R12: `ld_en` or `restore_en` in a cycle with `acc_en` = 1 is ignored; only the access itself can move the pointer.
- R13: `ptr_rdbk` shows the adjusted pointer during a committing access and the current pointer otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Stack access in this cycle |
| task_id | input | 4 | Task issuing the instruction |
| adj_code | input | 3 | Signed pointer adjustment |
| zchk | input | 1 | Enable zero-offset underflow check |
| wr_adj | input | 1 | Write at the adjusted pointer |
| ld_en | input | 1 | Load pointer from bus |
| ld_val | input | 8 | Pointer load value |
| save_stb | input | 1 | Save current pointer |
| restore_en | input | 1 | Restore pointer from saved copy |
| rd_addr | output | 8 | Stack read address |
| wr_addr | output | 8 | Stack write address |
| ptr_rdbk | output | 8 | Pointer readback |
| hold | output | 1 | Stall the offending instruction |
| fault_req | output | 1 | Wakeup request for the fault task |
| ovf_flag | output | 1 | Sticky overflow flag |
| und_flag | output | 1 | Sticky underflow flag |

## Verification
The hardest cases to reach are the bounds errors at the region edges: offset 63 with a positive step, small offsets with large negative steps, and the zero-check on an offset that starts or ends at 0. Uniform random stimulus seldom walks the pointer onto these edges. The stimulus therefore reloads the pointer through the load bus, and in the random phase it biases loads toward offsets 0, 1, 62 and 63 before each burst of mixed accesses. The random phase also mixes other tasks and restores in with the accesses. This shows that wrapping, refusal of loads, and flag retention all behave correctly next to the error cases.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

    localparam int DEF_PTR_W    = 8;
    localparam int DEF_REGION_W = 2;
    localparam int DEF_ADJ_W    = 3;
    localparam int DEF_TASK_W   = 4;

    // Source of the next pointer value
    typedef enum logic [1:0] {
        UPD_KEEP    = 2'd0,
        UPD_ADJ     = 2'd1,
        UPD_LOAD    = 2'd2,
        UPD_RESTORE = 2'd3
    } upd_sel_e;

    // Bounds-error classification of one access
    typedef struct packed {
        logic ovf;
        logic und;
    } bound_err_t;

    function automatic logic any_err(bound_err_t e);
        return e.ovf | e.und;
    endfunction

endpackage

// File: rtl/stkptr_adjust.sv
module stkptr_adjust
    import stkptr_pkg::*;
#(
    parameter int OFF_W = 6,
    parameter int ADJ_W = 3
) (
    input  logic [OFF_W-1:0] off,
    input  logic [ADJ_W-1:0] adj,
    input  logic             zchk,
    input  logic             chk_en,
    output logic [OFF_W-1:0] next_off,
    output bound_err_t       err
);
    localparam int SW = OFF_W + 2;
    localparam logic signed [SW-1:0] TOP_OFF = SW'((1 << OFF_W) - 1);

    logic signed [SW-1:0] adj_s;
    logic signed [SW-1:0] off_s;
    logic signed [SW-1:0] sum_s;
    logic                 below;
    logic                 above;
    logic                 zero_hit;

    always_comb begin
        adj_s    = {{(SW-ADJ_W){adj[ADJ_W-1]}}, adj};
        off_s    = {2'b00, off};
        sum_s    = off_s + adj_s;
        below    = sum_s < 0;
        above    = sum_s > TOP_OFF;
        zero_hit = zchk && ((off == '0) || (sum_s == '0));
        next_off = sum_s[OFF_W-1:0];
        err.ovf  = chk_en && above;
        err.und  = chk_en && (below || zero_hit);
    end

endmodule

// File: rtl/stkptr_ctrl.sv
module stkptr_ctrl
    import stkptr_pkg::*;
#(
    parameter int TASK_W   = 4,
    parameter int EMU_TASK = 0
) (
    input  logic              acc_en,
    input  logic [TASK_W-1:0] task_id,
    input  logic              ld_en,
    input  logic              restore_en,
    input  bound_err_t        err,
    output logic              chk_en,
    output logic              stall,
    output upd_sel_e          upd_sel
);
    always_comb begin
        chk_en = acc_en && (task_id == TASK_W'(EMU_TASK));
        stall  = any_err(err);
        if (acc_en) begin
            upd_sel = stall ? UPD_KEEP : UPD_ADJ;
        end else if (ld_en) begin
            upd_sel = UPD_LOAD;
        end else if (restore_en) begin
            upd_sel = UPD_RESTORE;
        end else begin
            upd_sel = UPD_KEEP;
        end
    end

endmodule

// File: rtl/stkptr_regs.sv
module stkptr_regs
    import stkptr_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  upd_sel_e         upd_sel,
    input  logic [PTR_W-1:0] adj_ptr,
    input  logic [PTR_W-1:0] ld_val,
    input  logic             save_stb,
    input  logic             flag_upd,
    input  bound_err_t       err,
    output logic [PTR_W-1:0] ptr,
    output bound_err_t       flags
);
    logic [PTR_W-1:0] saved;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else begin
            case (upd_sel)
                UPD_ADJ:     ptr <= adj_ptr;
                UPD_LOAD:    ptr <= ld_val;
                UPD_RESTORE: ptr <= saved;
                default:     ptr <= ptr;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            saved <= '0;
        end else if (save_stb) begin
            saved <= ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (flag_upd) begin
            flags <= err;
        end
    end

endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
    import stkptr_pkg::*;
#(
    parameter int PTR_W    = DEF_PTR_W,
    parameter int REGION_W = DEF_REGION_W,
    parameter int ADJ_W    = DEF_ADJ_W,
    parameter int TASK_W   = DEF_TASK_W,
    parameter int EMU_TASK = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic [TASK_W-1:0] task_id,
    input  logic [ADJ_W-1:0]  adj_code,
    input  logic              zchk,
    input  logic              wr_adj,
    input  logic              ld_en,
    input  logic [PTR_W-1:0]  ld_val,
    input  logic              save_stb,
    input  logic              restore_en,
    output logic [PTR_W-1:0]  rd_addr,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [PTR_W-1:0]  ptr_rdbk,
    output logic              hold,
    output logic              fault_req,
    output logic              ovf_flag,
    output logic              und_flag
);
    localparam int OFF_W = PTR_W - REGION_W;

    logic [PTR_W-1:0] ptr;
    logic [OFF_W-1:0] next_off;
    logic [PTR_W-1:0] adj_ptr;
    bound_err_t       err;
    bound_err_t       flags;
    logic             chk_en;
    logic             stall;
    upd_sel_e         upd_sel;

    stkptr_adjust #(.OFF_W(OFF_W), .ADJ_W(ADJ_W)) u_adjust (
        .off      (ptr[OFF_W-1:0]),
        .adj      (adj_code),
        .zchk     (zchk),
        .chk_en   (chk_en),
        .next_off (next_off),
        .err      (err)
    );

    stkptr_ctrl #(.TASK_W(TASK_W), .EMU_TASK(EMU_TASK)) u_ctrl (
        .acc_en     (acc_en),
        .task_id    (task_id),
        .ld_en      (ld_en),
        .restore_en (restore_en),
        .err        (err),
        .chk_en     (chk_en),
        .stall      (stall),
        .upd_sel    (upd_sel)
    );

    stkptr_regs #(.PTR_W(PTR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .upd_sel  (upd_sel),
        .adj_ptr  (adj_ptr),
        .ld_val   (ld_val),
        .save_stb (save_stb),
        .flag_upd (chk_en),
        .err      (err),
        .ptr      (ptr),
        .flags    (flags)
    );

    always_comb begin
        adj_ptr   = {ptr[PTR_W-1 -: REGION_W], next_off};
        rd_addr   = ptr;
        wr_addr   = wr_adj ? adj_ptr : ptr;
        ptr_rdbk  = (upd_sel == UPD_ADJ) ? adj_ptr : ptr;
        hold      = stall;
        fault_req = stall;
        ovf_flag  = flags.ovf;
        und_flag  = flags.und;
    end

endmodule

// File: rtl/stkptr_checker.sv
module stkptr_checker #(
    parameter int PTR_W  = 8,
    parameter int TASK_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_en,
    input logic [TASK_W-1:0] task_id,
    input logic              wr_adj,
    input logic [PTR_W-1:0]  rd_addr,
    input logic [PTR_W-1:0]  wr_addr,
    input logic [PTR_W-1:0]  ptr_rdbk,
    input logic              hold,
    input logic              fault_req,
    input logic              ovf_flag,
    input logic              und_flag
);
    localparam int RB = PTR_W - 2;

    a_r8_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        hold |=> rd_addr == $past(rd_addr));

    a_r8_req_with_hold: assert property (@(posedge clk) disable iff (rst)
        fault_req |-> hold);

    a_r2_region_kept: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> rd_addr[PTR_W-1:RB] == $past(rd_addr[PTR_W-1:RB]));

    a_r6_no_hold_other: assert property (@(posedge clk) disable iff (rst)
        (task_id != '0) |-> !hold);

    a_r13_rdbk_commits: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> rd_addr == $past(ptr_rdbk));

    a_r9_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !(acc_en && task_id == '0) |=> $stable(ovf_flag) && $stable(und_flag));

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ovf_flag, und_flag}));

    a_r7_wr_plain: assert property (@(posedge clk) disable iff (rst)
        !wr_adj |-> wr_addr == rd_addr);

    a_r13_rdbk_idle: assert property (@(posedge clk) disable iff (rst)
        !acc_en |-> ptr_rdbk == rd_addr);

endmodule

bind stkptr_unit stkptr_checker #(.PTR_W(PTR_W), .TASK_W(TASK_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_en    (acc_en),
    .task_id   (task_id),
    .wr_adj    (wr_adj),
    .rd_addr   (rd_addr),
    .wr_addr   (wr_addr),
    .ptr_rdbk  (ptr_rdbk),
    .hold      (hold),
    .fault_req (fault_req),
    .ovf_flag  (ovf_flag),
    .und_flag  (und_flag)
);

// File: tb/test_stkptr_unit.sv
module test_stkptr_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_en = 1'b0;
    logic [3:0] task_id = '0;
    logic [2:0] adj_code = '0;
    logic       zchk = 1'b0;
    logic       wr_adj = 1'b0;
    logic       ld_en = 1'b0;
    logic [7:0] ld_val = '0;
    logic       save_stb = 1'b0;
    logic       restore_en = 1'b0;
    logic [7:0] rd_addr, wr_addr, ptr_rdbk;
    logic       hold, fault_req, ovf_flag, und_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] m_ptr   = '0;
    logic [7:0] m_saved = '0;
    logic       m_ovf   = 1'b0;
    logic       m_und   = 1'b0;

    always #5 clk = ~clk;

    stkptr_unit i_stkptr_unit (
        .clk(clk), .rst(rst), .acc_en(acc_en), .task_id(task_id),
        .adj_code(adj_code), .zchk(zchk), .wr_adj(wr_adj), .ld_en(ld_en),
        .ld_val(ld_val), .save_stb(save_stb), .restore_en(restore_en),
        .rd_addr(rd_addr), .wr_addr(wr_addr), .ptr_rdbk(ptr_rdbk),
        .hold(hold), .fault_req(fault_req), .ovf_flag(ovf_flag),
        .und_flag(und_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int sadj(input logic [2:0] c);
        return c[2] ? int'(c) - 8 : int'(c);
    endfunction

    // Drive current inputs for one cycle, check comb outputs, then model commit.
    task automatic step();
        int         sum;
        logic       emu, e_ovf, e_und, err;
        logic [7:0] adj_p, nxt;
        #2;
        sum   = int'(m_ptr[5:0]) + sadj(adj_code);
        emu   = acc_en && task_id == 4'd0;
        e_ovf = emu && sum > 63;
        e_und = emu && (sum < 0 || (zchk && (m_ptr[5:0] == 0 || sum == 0)));
        err   = e_ovf | e_und;
        adj_p = {m_ptr[7:6], 6'(sum)};
        check("R7 rd_addr", rd_addr, m_ptr);
        check("R7 wr_addr", wr_addr, wr_adj ? adj_p : m_ptr);
        check("R8 hold", hold, err);
        check("R8 fault_req", fault_req, err);
        check("R13 ptr_rdbk", ptr_rdbk, (acc_en && !err) ? adj_p : m_ptr);
        nxt = m_ptr;
        if (acc_en) begin
            if (!err) nxt = adj_p;
        end else if (ld_en) nxt = ld_val;
        else if (restore_en) nxt = m_saved;
        if (save_stb) m_saved = m_ptr;
        if (emu) begin
            m_ovf = e_ovf;
            m_und = e_und;
        end
        m_ptr = nxt;
        @(posedge clk);
        #1;
        check("R2 pointer", rd_addr, m_ptr);
        check("R9 ovf_flag", ovf_flag, m_ovf);
        check("R9 und_flag", und_flag, m_und);
    endtask

    task automatic idle();
        acc_en = 0; ld_en = 0; restore_en = 0; save_stb = 0;
        zchk = 0; wr_adj = 0; task_id = 0; adj_code = 0;
    endtask

    task automatic access(input logic [3:0] t, input logic [2:0] a, input logic z, input logic w);
        idle();
        acc_en = 1; task_id = t; adj_code = a; zchk = z; wr_adj = w;
        step();
    endtask

    task automatic load(input logic [7:0] v);
        idle();
        ld_en = 1; ld_val = v;
        step();
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 ptr", rd_addr, 8'h00);
        check("R1 rdbk", ptr_rdbk, 8'h00);
        check("R1 flags", {ovf_flag, und_flag}, 2'b00);

        // R10 load region 2 offset 62
        load(8'hBE);
        check("R10 loaded", rd_addr, 8'hBE);
        access(4'd0, 3'd1, 0, 0);                 // to 63
        check("R2 +1", rd_addr, 8'hBF);
        access(4'd0, 3'd1, 0, 0);                 // overflow
        check("R3 ovf kept ptr", rd_addr, 8'hBF);
        check("R3 ovf flag", {ovf_flag, und_flag}, 2'b10);

        // R4 underflow below zero
        load(8'h41);
        access(4'd0, 3'd6, 0, 0);                 // 1-2
        check("R4 und ptr", rd_addr, 8'h41);
        check("R4 und flag", {ovf_flag, und_flag}, 2'b01);

        // R5 zero check on original offset, then clean access clears flags
        load(8'h40);
        access(4'd0, 3'd1, 1, 0);
        check("R5 orig zero", {rd_addr, und_flag}, {8'h40, 1'b1});
        access(4'd0, 3'd1, 0, 0);
        check("R9 cleared", {rd_addr, ovf_flag, und_flag}, {8'h41, 2'b00});
        // R5 zero check on final offset
        access(4'd0, 3'd7, 1, 0);
        check("R5 final zero", {rd_addr, und_flag}, {8'h41, 1'b1});

        // R6 other task wraps, flags untouched
        load(8'h00);
        access(4'd5, 3'd7, 1, 0);
        check("R6 wrap", {rd_addr, und_flag}, {8'h3F, 1'b1});

        // R7 write at adjusted pointer
        load(8'hC4);
        idle(); acc_en = 1; adj_code = 3'd2; wr_adj = 1;
        #2;
        check("R7 wr adjusted", wr_addr, 8'hC6);
        check("R13 rdbk adjusted", ptr_rdbk, 8'hC6);
        #0; step_tail();

        // R11 save and restore
        idle(); save_stb = 1; step();
        load(8'h12);
        idle(); restore_en = 1; step();
        check("R11 restored", rd_addr, 8'hC6);

        // R12 load and restore ignored during access
        idle(); acc_en = 1; adj_code = 3'd1; ld_en = 1; ld_val = 8'h77; step();
        check("R12 load ignored", rd_addr, 8'hC7);
        load(8'h05);
        idle(); acc_en = 1; adj_code = 3'd0; restore_en = 1; step();
        check("R12 restore ignored", rd_addr, 8'h05);

        // Random phase with edge-biased loads
        for (int i = 0; i < 600; i++) begin
            idle();
            if (($urandom % 8) == 0) begin
                case ($urandom % 4)
                    0: ld_val = {2'($urandom), 6'd0};
                    1: ld_val = {2'($urandom), 6'd1};
                    2: ld_val = {2'($urandom), 6'd62};
                    default: ld_val = {2'($urandom), 6'd63};
                endcase
                ld_en = 1;
            end else begin
                acc_en     = ($urandom % 4) != 0;
                task_id    = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
                adj_code   = 3'($urandom);
                zchk       = 1'($urandom);
                wr_adj     = 1'($urandom);
                ld_en      = 1'($urandom);
                ld_val     = 8'($urandom);
                restore_en = 1'($urandom);
                save_stb   = 1'($urandom);
            end
            step();
        end

        finish_run();
    end

    // Remainder of a step whose inputs were already driven and checked early.
    task automatic step_tail();
        #0;
        m_ptr = m_ptr; // model already aligned; run standard step from same inputs
        step_inline();
    endtask

    task automatic step_inline();
        // Inputs are stable; comb checks in step() are still valid at this time.
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule